// File: doc/BRIEF.md
# SPI Byte FIFO and Interrupt Controller

This block sits between a register port and a byte-wide serial engine. It holds bytes that are waiting to be sent in a small transmit queue and bytes that have arrived in a small receive queue. It gives the engine a start strobe, the byte at the head of the transmit queue, and a flag that says whether that byte is valid. The engine reports each finished byte and each arrived byte. Serial shifting, clock generation and pin drivers are outside this block.

A two-bit mode field sets when interrupts are raised. The transmit request is raised after a chosen number of finished bytes (1 to 4). The receive request is raised when the receive queue reaches a fill level of 1, 1, 3 or full. Each queue has a flush control that acts for as long as it is held. On receive overflow the block either replaces the newest stored byte or discards the new one. A transfer-mode bit chooses what starts a transfer: a transmit write, which uses only the transmit interrupt, or a receive read, which uses only the receive interrupt.

Top module: `spi_fifo_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, both occupancy counts are 0, both interrupt requests are 0 and the start strobe is 0.
- R2: Accepted transmit writes leave in write order. The head byte is shown on eng_tx_data and is removed by eng_byte_done. A write to a full transmit queue is ignored.
- R3: While cfg_tx_flush is 1, tx_count reads 0 from the next cycle on and transmit writes are ignored. After release, the next write becomes the head.
- R4: With cfg_xfer_on_write=1, irq_tx becomes 1 on the edge of the (mode+1)-th eng_byte_done since reset or since the previous raise (mode 0..3 gives 1..4). With cfg_xfer_on_write=0, irq_tx is never raised.
- R5: With cfg_xfer_on_write=0, irq_rx becomes 1 one cycle after rx_count first rises to the threshold or above: 1 for mode 0 and 1, 3 for mode 2, full for mode 3. With cfg_xfer_on_write=1, irq_rx is never raised.
- R6: While cfg_rx_flush is 1, the receive queue reads empty, arriving bytes are dropped and irq_rx is not raised.
- R7: With cfg_rx_overwrite=1, a byte that arrives at a full receive queue with no read in the same cycle replaces the most recently stored byte.
- R8: With cfg_rx_overwrite=0, such a byte is discarded and the stored bytes are unchanged.
- R9: An arrival and a read in the same cycle on a full receive queue keep rx_count at full and store the new byte behind the others.
- R10: eng_start is a one-cycle pulse in the cycle after the trigger. With cfg_xfer_on_write=1 the trigger is an accepted transmit write. With cfg_xfer_on_write=0 it is rd_rx_en, even while cfg_rx_flush is 1.
- R11: Interrupt requests are sticky and are cleared by a 1 on irq_clr_tx or irq_clr_rx. A raise in the same cycle wins over the clear. A cleared request stays 0 until the next crossing.
- R12: rd_rx_data shows the oldest stored receive byte, and rd_rx_en removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_irq_mode | input | 2 | Interrupt threshold mode |
| cfg_tx_flush | input | 1 | Hold transmit queue empty, ignore writes |
| cfg_rx_flush | input | 1 | Hold receive queue empty, drop arrivals |
| cfg_rx_overwrite | input | 1 | 1: replace newest on overflow, 0: discard |
| cfg_xfer_on_write | input | 1 | 1: write starts transfer, 0: read starts transfer |
| wr_tx_en | input | 1 | Transmit data write strobe |
| wr_tx_data | input | DATA_W | Transmit data |
| rd_rx_en | input | 1 | Receive data read strobe |
| rd_rx_data | output | DATA_W | Oldest receive byte |
| irq_clr_tx | input | 1 | Write-one clear of irq_tx |
| irq_clr_rx | input | 1 | Write-one clear of irq_rx |
| tx_count | output | CNT_W | Transmit queue occupancy |
| rx_count | output | CNT_W | Receive queue occupancy |
| eng_start | output | 1 | Transfer start pulse to engine |
| eng_tx_valid | output | 1 | Transmit head is valid |
| eng_tx_data | output | DATA_W | Transmit head byte |
| eng_byte_done | input | 1 | Engine finished one byte |
| eng_rx_valid | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | DATA_W | Received byte |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive interrupt request |

## Verification
The bench uses the default DEPTH=4 and DATA_W=8. With these values the full-queue receive threshold of mode 3 equals the queue depth, so each mode's threshold and both overflow policies can be reached within five arrivals. The 4-entry pointer wrap is exercised by every fill-and-drain sequence, and a simultaneous read and arrival on a full queue leaves the wrap position visible in the readback order.

// File: rtl/spi_fifo_pkg.sv
// Shared helpers for the SPI byte FIFO controller.
// Assumes a depth of at least 3 so that every receive threshold is reachable.
package spi_fifo_pkg;

    // Receive fill level that raises the receive request for a given mode.
    function automatic int rx_threshold(input logic [1:0] mode, input int depth);
        case (mode)
            2'd0, 2'd1: return 1;
            2'd2:       return 3;
            default:    return depth;
        endcase
    endfunction

endpackage

// File: rtl/spi_byte_fifo.sv
// Circular byte queue with level-held flush and an optional
// replace-newest policy when a push meets a full queue.
// Assumes push and pop are single-cycle strobes. A push and a pop
// in the same cycle on a full queue are both performed.
module spi_byte_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             ovw_en,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             push_ok
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr, newest;
    logic             full, empty, do_pop, do_ovw;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Decode occupancy and which operations take effect this cycle.
    always_comb begin
        full    = (count == CNT_W'(DEPTH));
        empty   = (count == '0);
        do_pop  = pop && !empty && !flush;
        push_ok = push && !flush && (!full || do_pop);
        do_ovw  = push && !flush && full && !do_pop && ovw_en;
        newest  = (wptr == '0) ? PTR_W'(DEPTH - 1) : wptr - 1'b1;
        head    = mem[rptr];
    end

    // Storage write: append at the tail or replace the newest entry.
    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wptr] <= din;
        else if (do_ovw)
            mem[newest] <= din;
    end

    // Pointer and occupancy update, with flush overriding everything.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= step(wptr);
            if (do_pop)  rptr <= step(rptr);
            case ({push_ok, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/spi_irq_unit.sv
// Sticky transmit and receive interrupt requests.
// Transmit: raised every (mode+1) completed bytes. Receive: raised when the
// receive occupancy first reaches the mode threshold (edge of the level).
// Assumes the mode is held stable while bytes are in flight. A raise wins
// over a same-cycle clear.
module spi_irq_unit
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             tx_irq_en,
    input  logic             rx_irq_en,
    input  logic             rx_flush,
    input  logic             byte_done,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             clr_tx,
    input  logic             clr_rx,
    output logic             irq_tx,
    output logic             irq_rx
);
    logic [1:0]       sent_cnt;
    logic             tx_hit, rx_above, rx_above_q, rx_hit;
    logic [CNT_W-1:0] rx_thr;

    // Threshold compares for both directions.
    always_comb begin
        rx_thr   = CNT_W'(rx_threshold(mode, DEPTH));
        tx_hit   = byte_done && (sent_cnt == mode);
        rx_above = (rx_count >= rx_thr);
        rx_hit   = rx_irq_en && !rx_flush && rx_above && !rx_above_q;
    end

    // Completed-byte counter that restarts at each transmit threshold.
    always_ff @(posedge clk) begin
        if (!rst_n)          sent_cnt <= '0;
        else if (tx_hit)     sent_cnt <= '0;
        else if (byte_done)  sent_cnt <= sent_cnt + 1'b1;
    end

    // Sticky request flags with write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_tx     <= 1'b0;
            irq_rx     <= 1'b0;
            rx_above_q <= 1'b0;
        end else begin
            rx_above_q <= rx_above;
            if (tx_hit && tx_irq_en) irq_tx <= 1'b1;
            else if (clr_tx)         irq_tx <= 1'b0;
            if (rx_hit)              irq_rx <= 1'b1;
            else if (clr_rx)         irq_rx <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_fifo_irq_ctrl.sv
// Top: transmit and receive byte queues for a serial engine, plus
// interrupt generation and transfer-start control.
// Assumes register strobes are single-cycle and that the engine pulses
// eng_byte_done once per shifted byte.
module spi_fifo_irq_ctrl #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_irq_mode,
    input  logic              cfg_tx_flush,
    input  logic              cfg_rx_flush,
    input  logic              cfg_rx_overwrite,
    input  logic              cfg_xfer_on_write,
    input  logic              wr_tx_en,
    input  logic [DATA_W-1:0] wr_tx_data,
    input  logic              rd_rx_en,
    output logic [DATA_W-1:0] rd_rx_data,
    input  logic              irq_clr_tx,
    input  logic              irq_clr_rx,
    output logic [CNT_W-1:0]  tx_count,
    output logic [CNT_W-1:0]  rx_count,
    output logic              eng_start,
    output logic              eng_tx_valid,
    output logic [DATA_W-1:0] eng_tx_data,
    input  logic              eng_byte_done,
    input  logic              eng_rx_valid,
    input  logic [DATA_W-1:0] eng_rx_data,
    output logic              irq_tx,
    output logic              irq_rx
);
    logic tx_accepted, rx_push_ok;

    spi_byte_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(cfg_tx_flush), .ovw_en(1'b0),
        .push(wr_tx_en), .din(wr_tx_data), .pop(eng_byte_done),
        .head(eng_tx_data), .count(tx_count), .push_ok(tx_accepted)
    );

    spi_byte_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(cfg_rx_flush), .ovw_en(cfg_rx_overwrite),
        .push(eng_rx_valid), .din(eng_rx_data), .pop(rd_rx_en),
        .head(rd_rx_data), .count(rx_count), .push_ok(rx_push_ok)
    );

    spi_irq_unit #(.DEPTH(DEPTH)) u_irq (
        .clk(clk), .rst_n(rst_n), .mode(cfg_irq_mode),
        .tx_irq_en(cfg_xfer_on_write), .rx_irq_en(!cfg_xfer_on_write),
        .rx_flush(cfg_rx_flush), .byte_done(eng_byte_done), .rx_count(rx_count),
        .clr_tx(irq_clr_tx), .clr_rx(irq_clr_rx), .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    // Transmit head is valid whenever the queue holds data.
    assign eng_tx_valid = (tx_count != '0);

    // Start strobe: accepted write or receive read, as the transfer mode selects.
    always_ff @(posedge clk) begin
        if (!rst_n) eng_start <= 1'b0;
        else        eng_start <= cfg_xfer_on_write ? tx_accepted : rd_rx_en;
    end
endmodule

// File: rtl/spi_fifo_irq_chk.sv
// Property checker for spi_fifo_irq_ctrl, attached by bind.
// Assumes only the top-level ports are visible.
module spi_fifo_irq_chk #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_tx_flush,
    input logic             cfg_rx_flush,
    input logic             cfg_xfer_on_write,
    input logic             wr_tx_en,
    input logic             rd_rx_en,
    input logic [CNT_W-1:0] tx_count,
    input logic [CNT_W-1:0] rx_count,
    input logic             eng_start,
    input logic             irq_clr_tx,
    input logic             irq_tx,
    input logic             irq_rx
);
    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= CNT_W'(DEPTH)) && (rx_count <= CNT_W'(DEPTH)));

    // R3
    tx_flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_tx_flush |=> (tx_count == '0));

    // R6
    rx_flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rx_flush && !irq_rx) |=> (!irq_rx && rx_count == '0));

    // R5
    rx_irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_xfer_on_write && !irq_rx) |=> !irq_rx);

    // R4
    tx_irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_xfer_on_write && !irq_tx) |=> !irq_tx);

    // R10
    start_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_xfer_on_write && wr_tx_en && !cfg_tx_flush && tx_count < CNT_W'(DEPTH))
        |=> eng_start);

    // R10
    start_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_xfer_on_write && rd_rx_en) |=> eng_start);

    // R11
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_tx && !irq_clr_tx) |=> irq_tx);
endmodule

bind spi_fifo_irq_ctrl spi_fifo_irq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_tx_flush(cfg_tx_flush), .cfg_rx_flush(cfg_rx_flush),
    .cfg_xfer_on_write(cfg_xfer_on_write), .wr_tx_en(wr_tx_en), .rd_rx_en(rd_rx_en),
    .tx_count(tx_count), .rx_count(rx_count), .eng_start(eng_start),
    .irq_clr_tx(irq_clr_tx), .irq_tx(irq_tx), .irq_rx(irq_rx)
);

// File: tb/sim_spi_fifo_irq_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_spi_fifo_irq_ctrl;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 4;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_irq_mode = '0;
    logic cfg_tx_flush = 0, cfg_rx_flush = 0, cfg_rx_overwrite = 0, cfg_xfer_on_write = 0;
    logic wr_tx_en = 0, rd_rx_en = 0, irq_clr_tx = 0, irq_clr_rx = 0;
    logic eng_byte_done = 0, eng_rx_valid = 0;
    logic [DATA_W-1:0] wr_tx_data = '0, eng_rx_data = '0;
    logic [DATA_W-1:0] rd_rx_data, eng_tx_data;
    logic [CNT_W-1:0]  tx_count, rx_count;
    logic eng_start, eng_tx_valid, irq_tx, irq_rx;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    spi_fifo_irq_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        {cfg_tx_flush, cfg_rx_flush, cfg_rx_overwrite, cfg_xfer_on_write} = '0;
        cfg_irq_mode = '0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic tx_write(input logic [7:0] d);
        wr_tx_en = 1'b1; wr_tx_data = d; tick(); wr_tx_en = 1'b0;
    endtask

    task automatic byte_done();
        eng_byte_done = 1'b1; tick(); eng_byte_done = 1'b0;
    endtask

    task automatic rx_arrive(input logic [7:0] d);
        eng_rx_valid = 1'b1; eng_rx_data = d; tick(); eng_rx_valid = 1'b0;
    endtask

    task automatic rx_read();
        rd_rx_en = 1'b1; tick(); rd_rx_en = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(); tick();
        chk("R1 tx_count", int'(tx_count), 0);
        chk("R1 rx_count", int'(rx_count), 0);
        chk("R1 irq_tx", int'(irq_tx), 0);
        chk("R1 irq_rx", int'(irq_rx), 0);
        chk("R1 eng_start", int'(eng_start), 0);
    endtask

    task automatic t_tx_order();
        do_reset(); cfg_xfer_on_write = 1'b1;
        for (int i = 0; i < 5; i++) tx_write(8'hA1 + 8'(i));
        chk("R2 full count", int'(tx_count), 4);
        for (int i = 0; i < 4; i++) begin
            chk("R2 head order", int'(eng_tx_data), 'hA1 + i);
            byte_done();
        end
        chk("R2 drained", int'(tx_count), 0);
        chk("R2 valid low", int'(eng_tx_valid), 0);
    endtask

    task automatic t_tx_flush();
        do_reset(); cfg_xfer_on_write = 1'b1;
        tx_write(8'h11); tx_write(8'h22);
        cfg_tx_flush = 1'b1; tick();
        chk("R3 flushed", int'(tx_count), 0);
        tx_write(8'h33);
        chk("R3 write ignored", int'(tx_count), 0);
        cfg_tx_flush = 1'b0; tick();
        chk("R3 after release", int'(tx_count), 0);
        tx_write(8'h44);
        chk("R3 new count", int'(tx_count), 1);
        chk("R3 new head", int'(eng_tx_data), 'h44);
    endtask

    task automatic t_tx_irq();
        for (int m = 0; m < 4; m++) begin
            do_reset(); cfg_xfer_on_write = 1'b1; cfg_irq_mode = 2'(m);
            for (int k = 1; k <= m + 1; k++) begin
                byte_done();
                chk("R4 tx threshold", int'(irq_tx), (k == m + 1) ? 1 : 0);
            end
            irq_clr_tx = 1'b1; tick(); irq_clr_tx = 1'b0;
            chk("R11 tx clear", int'(irq_tx), 0);
        end
        do_reset(); cfg_xfer_on_write = 1'b0;
        byte_done(); tick();
        chk("R4 tx gated in read mode", int'(irq_tx), 0);
        do_reset(); cfg_xfer_on_write = 1'b1;
        eng_byte_done = 1'b1; irq_clr_tx = 1'b1; tick();
        eng_byte_done = 1'b0; irq_clr_tx = 1'b0;
        chk("R11 raise beats clear", int'(irq_tx), 1);
    endtask

    task automatic t_rx_irq();
        for (int m = 0; m < 4; m++) begin
            int thr;
            thr = (m < 2) ? 1 : (m == 2) ? 3 : 4;
            do_reset(); cfg_irq_mode = 2'(m);
            for (int k = 1; k <= 4; k++) begin
                rx_arrive(8'(k)); tick();
                chk("R5 rx threshold", int'(irq_rx), (k >= thr) ? 1 : 0);
            end
        end
        do_reset(); cfg_xfer_on_write = 1'b1;
        for (int k = 0; k < 4; k++) rx_arrive(8'(k));
        tick();
        chk("R5 rx gated in write mode", int'(irq_rx), 0);
    endtask

    task automatic t_rx_clear();
        do_reset();
        rx_arrive(8'h5A); tick();
        chk("R11 rx raised", int'(irq_rx), 1);
        irq_clr_rx = 1'b1; tick(); irq_clr_rx = 1'b0; tick();
        chk("R11 rx stays clear at level", int'(irq_rx), 0);
        rx_read(); rx_arrive(8'h5B); tick();
        chk("R11 rx re-armed", int'(irq_rx), 1);
    endtask

    task automatic t_rx_flush();
        do_reset();
        cfg_rx_flush = 1'b1;
        rx_arrive(8'h01); rx_arrive(8'h02); tick();
        chk("R6 dropped", int'(rx_count), 0);
        chk("R6 no irq", int'(irq_rx), 0);
        rd_rx_en = 1'b1; tick(); rd_rx_en = 1'b0;
        chk("R10 read starts under flush", int'(eng_start), 1);
        cfg_rx_flush = 1'b0; tick();
        rx_arrive(8'h03);
        chk("R6 after release", int'(rx_count), 1);
        chk("R12 head", int'(rd_rx_data), 'h03);
    endtask

    task automatic t_overflow(input logic ovw);
        do_reset(); cfg_rx_overwrite = ovw;
        for (int i = 0; i < 5; i++) rx_arrive(8'h10 + 8'(i));
        chk(ovw ? "R7 count" : "R8 count", int'(rx_count), 4);
        for (int i = 0; i < 4; i++) begin
            int exp;
            exp = (i == 3) ? (ovw ? 'h14 : 'h13) : 'h10 + i;
            chk(ovw ? "R7 readback" : "R8 readback", int'(rd_rx_data), exp);
            rx_read();
        end
        chk("R12 drained", int'(rx_count), 0);
    endtask

    task automatic t_full_pushpop();
        do_reset();
        for (int i = 0; i < 4; i++) rx_arrive(8'h20 + 8'(i));
        chk("R12 head before", int'(rd_rx_data), 'h20);
        eng_rx_valid = 1'b1; eng_rx_data = 8'h55; rd_rx_en = 1'b1; tick();
        eng_rx_valid = 1'b0; rd_rx_en = 1'b0;
        chk("R9 count held", int'(rx_count), 4);
        for (int i = 0; i < 4; i++) begin
            chk("R9 order", int'(rd_rx_data), (i == 3) ? 'h55 : 'h21 + i);
            rx_read();
        end
    endtask

    task automatic t_start();
        do_reset(); cfg_xfer_on_write = 1'b1;
        tx_write(8'h77);
        chk("R10 write pulse", int'(eng_start), 1);
        tick();
        chk("R10 pulse one cycle", int'(eng_start), 0);
        cfg_tx_flush = 1'b1; tx_write(8'h78);
        chk("R10 ignored write no pulse", int'(eng_start), 0);
        cfg_tx_flush = 1'b0;
        rx_read();
        chk("R10 read no pulse in write mode", int'(eng_start), 0);
        cfg_xfer_on_write = 1'b0;
        rx_read();
        chk("R10 read pulse", int'(eng_start), 1);
        tx_write(8'h79);
        chk("R10 write no pulse in read mode", int'(eng_start), 0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_tx_order();
        t_tx_flush();
        t_tx_irq();
        t_rx_irq();
        t_rx_clear();
        t_rx_flush();
        t_overflow(1'b1);
        t_overflow(1'b0);
        t_full_pushpop();
        t_start();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule